// File: doc/BRIEF.md
# Event Ring Producer With Interrupt

This block sits on the device side of a host link and reports events to the host. Internal sources hand it requests of three kinds: transfer done, command done and state change. Each request carries a channel number and a status byte. The block turns each request into one fixed 32-bit record and writes it into a circular ring that lives in host memory. It then moves its own ring pointer forward and raises a one-cycle interrupt pulse, so that the host knows a new record is waiting.

The ring uses an inverted occupancy rule. The device writes at its read pointer (`rp`) and then advances it. The host frees slots by moving the write pointer (`wp`), which it loads through a small register port once it has consumed records. The ring is empty when `rp` is one slot ahead of `wp`. It is full when the two pointers are equal. A full ring never loses an event. The request waits at the input, with `ev_ready` low, until the host gives slots back.

Top module: `event_ring_producer`

## Requirements
- R1: After a synchronous active-low reset, `rp` is 1 and `wp` is 0 (the empty configuration). `mw_req` and `irq` are low and `ev_ready` is high. The first record goes to ring slot 1.
- R2: The record for slot `rp` is written at address `BASE_ADDR + 4*rp`. The record data is `{8'h00, 6'b0, kind[1:0], chan[7:0], status[7:0]}`, where kind is 1 for transfer done, 2 for command done and 3 for state change.
- R3: Once raised, `mw_req` stays high with stable `mw_addr` and `mw_data` until the cycle in which `mw_ack` is high.
- R4: `irq` goes high for exactly one cycle, in the cycle after the acknowledged write. `irq` never rises without such a write: an `mw_ack` while no write is requested has no effect.
- R5: `rp` advances by one slot for each acknowledged record. It wraps from `RING_DEPTH-1` to 0 and does not change otherwise.
- R6: When `rp` equals `wp`, the ring is full. `ev_ready` is low, no write starts, and a held request is kept and not dropped.
- R7: A pulse on `host_wp_we` loads `host_wp` into `wp` at that clock edge. A full ring therefore accepts the held request starting at the next cycle.
- R8: Only one record is in flight at a time. `ev_ready` is low from acceptance until the interrupt cycle has ended.
- R9: Records reach the ring in the order the requests were accepted, in consecutive slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event request present |
| ev_kind | input | 2 | Event kind (1 transfer done, 2 command done, 3 state change) |
| ev_chan | input | 8 | Channel the event refers to |
| ev_status | input | 8 | Status code of the event |
| ev_ready | output | 1 | Request accepted on this edge when high with ev_valid |
| mw_req | output | 1 | Memory write request |
| mw_addr | output | ADDR_W | Host address of the record |
| mw_data | output | 32 | Record contents |
| mw_ack | input | 1 | Memory write completed |
| host_wp_we | input | 1 | Host writes its ring pointer |
| host_wp | input | PTR_W | New host pointer value |
| irq | output | 1 | One-cycle interrupt pulse to the host |

## Verification
The hardest state to reach is the full ring with a request parked at the input. Reaching it takes a whole ring's worth of acknowledged records, and the host must not give back any slots along the way. The bench posts seven records without writing `wp`, which also carries `rp` across the wrap from 7 to 0. It then holds an eighth request for several cycles while it watches that nothing is written. Finally it releases the ring with a host pointer write and checks that the parked record lands in slot 0 intact. A stray acknowledge sent while the block is idle shows that an interrupt cannot be produced without a real write.

// File: rtl/evr_pkg.sv
// Shared types for the event ring producer.
// Assumes: fixed 32-bit record with 8-bit channel and status fields.
package evr_pkg;
    localparam int unsigned CHAN_W = 8;
    localparam int unsigned STAT_W = 8;
    localparam int unsigned REC_W  = 32;

    typedef enum logic [1:0] {
        EVK_RSVD      = 2'd0,
        EVK_XFER_DONE = 2'd1,
        EVK_CMD_DONE  = 2'd2,
        EVK_STATE_CHG = 2'd3
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e            kind;
        logic [CHAN_W-1:0]   chan;
        logic [STAT_W-1:0]   status;
    } ev_rec_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_WRITE  = 2'd1,
        SEQ_NOTIFY = 2'd2
    } seq_state_e;

    // Lay a captured request out as the 32-bit ring record.
    function automatic logic [REC_W-1:0] pack_rec(input ev_rec_t r);
        return {8'h00, 6'b0, r.kind, r.chan, r.status};
    endfunction
endpackage

// File: rtl/evr_ptrs.sv
// Ring pointer pair for the event ring.
// The device pointer rp names the next slot to fill and moves on each
// acknowledged record. The host pointer wp is loaded by the host.
// Full means rp == wp. Reset gives rp = wp + 1, which is the empty ring.
// Assumes DEPTH >= 2 and that the host never loads wp == rp while a
// record is in flight.
module evr_ptrs #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             host_we,
    input  logic [PTR_W-1:0] host_wp,
    output logic [PTR_W-1:0] rp,
    output logic             full
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] rp_q;
    logic [PTR_W-1:0] wp_q;

    // Device pointer: step modulo ring length on each acknowledged record.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rp_q <= PTR_W'(1);
        else if (adv)
            rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
    end

    // Host pointer: loaded by the host to hand slots back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wp_q <= '0;
        else if (host_we)
            wp_q <= host_wp;
    end

    assign rp   = rp_q;
    assign full = (rp_q == wp_q);

    // R5
    rp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && rp_q == LAST) |=> (rp_q == '0));
    // R5
    rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && rp_q != LAST) |=> (rp_q == $past(rp_q) + 1'b1));
    // R5
    rp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(rp_q));
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !full);
endmodule

// File: rtl/evr_fsm.sv
// Posting sequencer: takes one request, holds the memory write until it
// is acknowledged, then gives one interrupt cycle before taking the next.
// Assumes mw_ack is only meaningful while mw_req is high.
module evr_fsm
    import evr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [CHAN_W-1:0] ev_chan,
    input  logic [STAT_W-1:0] ev_status,
    input  logic              full,
    input  logic              mw_ack,
    output logic              ev_ready,
    output logic              mw_req,
    output logic              adv,
    output logic              irq,
    output ev_rec_t           rec
);
    seq_state_e state_q;
    ev_rec_t    rec_q;

    // Sequence through accept, write and notify; capture the request on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            rec_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (ev_valid && ev_ready) begin
                    rec_q   <= '{kind: ev_kind_e'(ev_kind), chan: ev_chan, status: ev_status};
                    state_q <= SEQ_WRITE;
                end
                SEQ_WRITE: if (mw_ack) state_q <= SEQ_NOTIFY;
                SEQ_NOTIFY: state_q <= SEQ_IDLE;
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign ev_ready = (state_q == SEQ_IDLE) && !full;
    assign mw_req   = (state_q == SEQ_WRITE);
    assign adv      = mw_req && mw_ack;
    assign irq      = (state_q == SEQ_NOTIFY);
    assign rec      = rec_q;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && !mw_ack) |=> (mw_req && $stable(rec_q)));
    // R4
    irq_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mw_req && mw_ack));
    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req || irq) |-> !ev_ready);
endmodule

// File: rtl/evr_fmt.sv
// Record formatter: turns the captured request and the device pointer
// into the host address and data of the ring write.
// Assumes BASE_ADDR is aligned to the record size.
module evr_fmt
    import evr_pkg::*;
#(
    parameter int unsigned          PTR_W      = 3,
    parameter int unsigned          ADDR_W     = 32,
    parameter int unsigned          ELEM_BYTES = 4,
    parameter logic [ADDR_W-1:0]    BASE_ADDR  = 'h1000
) (
    input  ev_rec_t           rec,
    input  logic [PTR_W-1:0]  rp,
    output logic [ADDR_W-1:0] addr,
    output logic [REC_W-1:0]  data
);
    // Slot address and record layout.
    always_comb begin
        addr = BASE_ADDR + ADDR_W'(rp) * ADDR_W'(ELEM_BYTES);
        data = pack_rec(rec);
    end
endmodule

// File: rtl/event_ring_producer.sv
// Event ring producer: posts event records into a host-resident ring,
// advances the device pointer on write acknowledge, then pulses irq.
// Assumes the host memory write port completes each request with mw_ack.
module event_ring_producer
    import evr_pkg::*;
#(
    parameter int unsigned       RING_DEPTH = 8,
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h1000,
    parameter int unsigned       PTR_W      = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [7:0]        ev_chan,
    input  logic [7:0]        ev_status,
    output logic              ev_ready,
    output logic              mw_req,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [31:0]       mw_data,
    input  logic              mw_ack,
    input  logic              host_wp_we,
    input  logic [PTR_W-1:0]  host_wp,
    output logic              irq
);
    localparam int unsigned ELEM_BYTES = REC_W / 8;

    logic             adv;
    logic             full;
    logic [PTR_W-1:0] rp;
    ev_rec_t          rec;

    evr_ptrs #(.DEPTH(RING_DEPTH), .PTR_W(PTR_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .adv(adv), .host_we(host_wp_we),
        .host_wp(host_wp), .rp(rp), .full(full)
    );

    evr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_chan(ev_chan), .ev_status(ev_status), .full(full), .mw_ack(mw_ack),
        .ev_ready(ev_ready), .mw_req(mw_req), .adv(adv), .irq(irq), .rec(rec)
    );

    evr_fmt #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES),
              .BASE_ADDR(BASE_ADDR)) u_fmt (
        .rec(rec), .rp(rp), .addr(mw_addr), .data(mw_data)
    );

    // R3
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && !mw_ack) |=> ($stable(mw_addr) && $stable(mw_data)));
    // R6
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !mw_req && !irq) |=> !mw_req);
endmodule

// File: tb/event_ring_producer_bench.sv
module event_ring_producer_bench;
    localparam int DEPTH = 8;
    localparam logic [31:0] BASE = 32'h1000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ev_valid = 0;
    logic [1:0]  ev_kind = 0;
    logic [7:0]  ev_chan = 0;
    logic [7:0]  ev_status = 0;
    logic        ev_ready;
    logic        mw_req;
    logic [31:0] mw_addr;
    logic [31:0] mw_data;
    logic        mw_ack = 0;
    logic        host_wp_we = 0;
    logic [2:0]  host_wp = 0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int model_rp = 1;

    always #10 clk = ~clk;

    event_ring_producer u_event_ring_producer (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_chan(ev_chan), .ev_status(ev_status), .ev_ready(ev_ready),
        .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack),
        .host_wp_we(host_wp_we), .host_wp(host_wp), .irq(irq)
    );

    // kind, chan, status, ack delay
    localparam logic [21:0] VECS [0:4] = '{
        {2'd1, 8'h03, 8'h00, 4'd0},
        {2'd2, 8'h00, 8'h7F, 4'd1},
        {2'd3, 8'hFF, 8'h02, 4'd3},
        {2'd1, 8'h40, 8'hC1, 4'd0},
        {2'd2, 8'h11, 8'hEE, 4'd2}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rec_of(input logic [1:0] k, input logic [7:0] c,
                                           input logic [7:0] s);
        return {8'h00, 6'b0, k, c, s};
    endfunction

    // Checks after acceptance: write held, ack, interrupt pulse.
    task automatic finish_post(input logic [31:0] exp_data, input int dly);
        @(negedge clk);
        ev_valid = 0;
        chk("R3", "mw_req raised", 32'(mw_req), 32'd1);
        chk("R8", "ready low in flight", 32'(ev_ready), 32'd0);
        chk("R2", "address", mw_addr, BASE + 32'(model_rp) * 4);
        chk("R2", "data", mw_data, exp_data);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk("R3", "request held", 32'(mw_req), 32'd1);
            chk("R3", "address held", mw_addr, BASE + 32'(model_rp) * 4);
            chk("R4", "no irq before ack", 32'(irq), 32'd0);
        end
        mw_ack = 1;
        @(negedge clk);
        mw_ack = 0;
        chk("R4", "irq after ack", 32'(irq), 32'd1);
        chk("R3", "request dropped after ack", 32'(mw_req), 32'd0);
        @(negedge clk);
        chk("R4", "irq single cycle", 32'(irq), 32'd0);
        model_rp = (model_rp + 1) % DEPTH;
    endtask

    task automatic post(input logic [1:0] k, input logic [7:0] c,
                        input logic [7:0] s, input int dly);
        @(negedge clk);
        chk("R6", "ready when not full", 32'(ev_ready), 32'd1);
        ev_valid = 1; ev_kind = k; ev_chan = c; ev_status = s;
        finish_post(rec_of(k, c, s), dly);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "ready after reset", 32'(ev_ready), 32'd1);
        chk("R1", "no request after reset", 32'(mw_req), 32'd0);
        chk("R1", "no irq after reset", 32'(irq), 32'd0);

        // stray acknowledge while idle has no effect
        mw_ack = 1;
        @(negedge clk);
        mw_ack = 0;
        chk("R4", "no irq from stray ack", 32'(irq), 32'd0);
        @(negedge clk);
        chk("R4", "still no irq", 32'(irq), 32'd0);

        // table of vectors; first lands in slot 1 (R1), consecutive order (R9)
        for (int v = 0; v < 5; v++)
            post(VECS[v][21:20], VECS[v][19:12], VECS[v][11:4], int'(VECS[v][3:0]));

        // slots 6 and 7, then rp wraps to 0 and equals wp: full (R5)
        post(2'd3, 8'h06, 8'h60, 0);
        post(2'd1, 8'h07, 8'h70, 1);
        chk("R5", "model wrapped", 32'(model_rp), 32'd0);

        // full ring: request held, nothing written (R6)
        @(negedge clk);
        ev_valid = 1; ev_kind = 2'd3; ev_chan = 8'hAA; ev_status = 8'h55;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R6", "ready low when full", 32'(ev_ready), 32'd0);
            chk("R6", "no write when full", 32'(mw_req), 32'd0);
        end
        // host frees slots (R7)
        host_wp = 3'd5; host_wp_we = 1;
        @(negedge clk);
        host_wp_we = 0;
        chk("R7", "ready after host pointer load", 32'(ev_ready), 32'd1);
        // held record lands in slot 0 intact (R6, R9, R5 wrap)
        finish_post(rec_of(2'd3, 8'hAA, 8'h55), 2);
        post(2'd2, 8'h01, 8'h01, 0);

        // reset mid-stream returns to the empty configuration (R1)
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_rp = 1;
        @(negedge clk);
        chk("R1", "ready after second reset", 32'(ev_ready), 32'd1);
        post(2'd1, 8'h22, 8'h33, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule